// File: doc/BRIEF.md
# Ethernet MAC Descriptor Ring Controller

This block holds the buffer descriptors that sit between software and a small Ethernet MAC. There are two rings, one for sending and one for receiving, and each has four slots. Every slot shows three registers to software: a buffer address word, a length word and a status word. Because each buffer starts on a 2 KiB boundary, the low bits of the address word are free. They carry an enable flag that software sets, a done flag that hardware sets, and, in slot 0 only, the index of the slot the hardware will service next.

On the send side, the controller looks only at the slot under its current index. If that slot is enabled and not yet done, it offers the slot's buffer address and byte count to the frame sender. The byte count is capped at 1518. When the sender reports completion, the controller stores the abort, excessive-collision and collision-count results, sets done and steps to the next slot. On the receive side, the controller shows the buffer address of the current slot to the frame receiver. At each frame end it writes the frame length and error flags into the slot, sets done and steps on. If the current slot is not available, the frame is dropped, and the next frame that is stored reports that a frame was missed. Software releases a finished slot by rewriting its address word, and writing zero clears it completely.

Top module: `mac_desc_ring`

## Requirements
- R1: After reset both ring indices are 0 and every register of every slot reads 0; txReq is low.
- R2: While the current send slot has enable set and done clear, txReq is high and txBufAddr equals that slot's buffer base (address word bits 31:11, low 11 bits zero).
- R3: txLen equals the slot's length word (bits 10:0) when that value is 1518 or less, and equals 1518 otherwise.
- R4: A txComplete pulse while txReq is high writes the send status word of the current slot, with bit 0 set to abort, bit 1 to excessive collision and bits 5:2 to the collision count. It also sets done (address bit 1) and advances the send index by one.
- R5: When the current send slot is not ready, txReq stays low and the index does not move, even if a later slot is enabled.
- R6: Writing an address word loads bits 31:11 as the base and bit 0 as enable, and clears done. Written bits 10:1 are ignored, so writing zero clears both enable and done.
- R7: Bits 3:2 of slot 0's address word hold the ring's current index. These bits read 0 in the address words of slots 1 to 3.
- R8: A receive frame end in a ready current slot stores the status word of that slot: length in bits 13:0 (CRC included, as given), and flags in bits 15 to 23 (unknown control, length error, CRC error, medium error, late collision, too long, runt, watchdog, dribble). It also sets done and advances the receive index.
- R9: A frame end while the current receive slot is not ready changes no slot and no index. The next stored frame has bit 14 (missed) set, and the frame stored after that has it clear.
- R10: Status bit 24 is the OR of the flags in bits 15 to 22. The dribble flag and the missed flag do not set it.
- R11: Both indices wrap from slot 3 back to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Software register write strobe |
| regAddr | input | 5 | Register select: {ring (1 = receive), slot[1:0], kind[1:0]}; kind 0 address, 1 length, 2 status |
| regWrData | input | 32 | Software write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| txReq | output | 1 | Current send slot offered to the frame sender |
| txBufAddr | output | 32 | Buffer address of the current send slot |
| txLen | output | 11 | Byte count to send, capped at 1518 |
| txComplete | input | 1 | Sender finished the offered frame (one-cycle pulse) |
| txAbort | input | 1 | Frame aborted |
| txExcessCol | input | 1 | Gave up after 16 attempts |
| txColCount | input | 4 | Collisions seen |
| rxBufReady | output | 1 | Current receive slot can take a frame |
| rxBufAddr | output | 32 | Buffer address of the current receive slot |
| rxFrameEnd | input | 1 | End of a received frame (one-cycle pulse) |
| rxLen | input | 14 | Received length including CRC |
| rxFlags | input | 9 | Receive error flags, bit 0 unknown control through bit 8 dribble |

## Verification
The send path is driven through every slot in turn, with lengths below, at and above the 1518 cap and with four different mixes of abort, excessive-collision and collision count. This separates correct field placement and clamping from swapped fields and an off-by-one cap. A slot enabled ahead of an idle current slot shows whether the ring stalls or wrongly skips ahead. The receive path gets a frame with no slot available, then a CRC-error frame, then a dribble-only frame. Together these show that the missed bit goes to the right frame, is cleared afterwards, and is kept out of the error summary along with dribble.

// File: rtl/mac_ring_pkg.sv
package mac_ring_pkg;

  // register kinds inside a slot
  localparam logic [1:0] KIND_ADDR = 2'd0;
  localparam logic [1:0] KIND_LEN  = 2'd1;
  localparam logic [1:0] KIND_STAT = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic txRecord;  // store send result in current slot
    logic rxRecord;  // store received frame in current slot
    logic rxMiss;    // frame arrived with no slot available
  } ringStrobe_t;

endpackage

// File: rtl/ring_ctrl.sv
module ring_ctrl
  import mac_ring_pkg::*;
#(
  parameter int RING_DEPTH = 4,
  localparam int IDX_W = $clog2(RING_DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txCurReady,
  input  logic             rxCurReady,
  input  logic             txComplete,
  input  logic             rxFrameEnd,
  output logic [IDX_W-1:0] txIdx,
  output logic [IDX_W-1:0] rxIdx,
  output logic             missPending,
  output logic             txReq,
  output ringStrobe_t      strobe
);

  function automatic logic [IDX_W-1:0] nextIdx(input logic [IDX_W-1:0] cur);
    return (cur == IDX_W'(RING_DEPTH - 1)) ? '0 : cur + 1'b1;
  endfunction

  always_comb begin
    txReq           = txCurReady;
    strobe.txRecord = txComplete && txCurReady;
    strobe.rxRecord = rxFrameEnd && rxCurReady;
    strobe.rxMiss   = rxFrameEnd && !rxCurReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txIdx       <= '0;
      rxIdx       <= '0;
      missPending <= 1'b0;
    end else begin
      if (strobe.txRecord) txIdx <= nextIdx(txIdx);
      if (strobe.rxRecord) begin
        rxIdx       <= nextIdx(rxIdx);
        missPending <= 1'b0;
      end else if (strobe.rxMiss) begin
        missPending <= 1'b1;
      end
    end
  end

  // R9: a dropped frame leaves a pending missed mark
  a_r9_miss_marked: assert property (@(posedge clk) disable iff (!rstN)
    (rxFrameEnd && !rxCurReady) |=> missPending);

  // R5: without a completion on a ready slot the send index holds
  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(txComplete && txCurReady) |=> $stable(txIdx));

endmodule

// File: rtl/ring_datapath.sv
module ring_datapath
  import mac_ring_pkg::*;
#(
  parameter int RING_DEPTH = 4,
  parameter int ALIGN_BITS = 11,
  parameter int TX_LEN_W   = 11,
  parameter int TX_LEN_MAX = 1518,
  parameter int RX_LEN_W   = 14,
  parameter int RX_FLAG_W  = 9,
  localparam int IDX_W     = $clog2(RING_DEPTH),
  localparam int REG_AW    = 1 + IDX_W + 2,
  localparam int RX_STAT_W = RX_LEN_W + RX_FLAG_W + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic [IDX_W-1:0]     txIdx,
  input  logic [IDX_W-1:0]     rxIdx,
  input  logic                 missPending,
  input  ringStrobe_t          strobe,
  input  logic                 txAbort,
  input  logic                 txExcessCol,
  input  logic [3:0]           txColCount,
  input  logic [RX_LEN_W-1:0]  rxLen,
  input  logic [RX_FLAG_W-1:0] rxFlags,
  output logic                 txCurReady,
  output logic                 rxCurReady,
  output logic [31:0]          txBufAddr,
  output logic [TX_LEN_W-1:0]  txLen,
  output logic [31:0]          rxBufAddr
);

  logic                  regRing;
  logic [IDX_W-1:0]      regSlot;
  logic [1:0]            regKind;

  logic [31:ALIGN_BITS]  txBase [RING_DEPTH];
  logic                  txEn   [RING_DEPTH];
  logic                  txDone [RING_DEPTH];
  logic [TX_LEN_W-1:0]   txLenR [RING_DEPTH];
  logic [5:0]            txStat [RING_DEPTH];
  logic [31:ALIGN_BITS]  rxBase [RING_DEPTH];
  logic                  rxEn   [RING_DEPTH];
  logic                  rxDone [RING_DEPTH];
  logic [RX_STAT_W-1:0]  rxStat [RING_DEPTH];

  logic                  rxSummary;

  assign regRing   = regAddr[REG_AW-1];
  assign regSlot   = regAddr[IDX_W+1:2];
  assign regKind   = regAddr[1:0];
  assign rxSummary = |rxFlags[RX_FLAG_W-2:0];

  always_ff @(posedge clk) begin
    for (int s = 0; s < RING_DEPTH; s++) begin
      if (!rstN) begin
        txBase[s] <= '0; txEn[s] <= 1'b0; txDone[s] <= 1'b0;
        txLenR[s] <= '0; txStat[s] <= '0;
        rxBase[s] <= '0; rxEn[s] <= 1'b0; rxDone[s] <= 1'b0;
        rxStat[s] <= '0;
      end else begin
        // send ring slot
        if (regWrEn && !regRing && regSlot == IDX_W'(s) && regKind == KIND_ADDR) begin
          txBase[s] <= regWrData[31:ALIGN_BITS];
          txEn[s]   <= regWrData[0];
          txDone[s] <= 1'b0;
        end else if (strobe.txRecord && txIdx == IDX_W'(s)) begin
          txDone[s] <= 1'b1;
        end
        if (regWrEn && !regRing && regSlot == IDX_W'(s) && regKind == KIND_LEN)
          txLenR[s] <= regWrData[TX_LEN_W-1:0];
        if (strobe.txRecord && txIdx == IDX_W'(s))
          txStat[s] <= {txColCount, txExcessCol, txAbort};
        // receive ring slot
        if (regWrEn && regRing && regSlot == IDX_W'(s) && regKind == KIND_ADDR) begin
          rxBase[s] <= regWrData[31:ALIGN_BITS];
          rxEn[s]   <= regWrData[0];
          rxDone[s] <= 1'b0;
        end else if (strobe.rxRecord && rxIdx == IDX_W'(s)) begin
          rxDone[s] <= 1'b1;
        end
        if (strobe.rxRecord && rxIdx == IDX_W'(s))
          rxStat[s] <= {rxSummary, rxFlags, missPending, rxLen};
      end
    end
  end

  always_comb begin
    txCurReady = txEn[txIdx] && !txDone[txIdx];
    rxCurReady = rxEn[rxIdx] && !rxDone[rxIdx];
    txBufAddr  = '0;
    txBufAddr[31:ALIGN_BITS] = txBase[txIdx];
    rxBufAddr  = '0;
    rxBufAddr[31:ALIGN_BITS] = rxBase[rxIdx];
    txLen = (txLenR[txIdx] > TX_LEN_W'(TX_LEN_MAX)) ? TX_LEN_W'(TX_LEN_MAX) : txLenR[txIdx];
  end

  always_comb begin
    regRdData = '0;
    case (regKind)
      KIND_ADDR: begin
        if (!regRing) begin
          regRdData[31:ALIGN_BITS] = txBase[regSlot];
          regRdData[1] = txDone[regSlot];
          regRdData[0] = txEn[regSlot];
          if (regSlot == '0) regRdData[IDX_W+1:2] = txIdx;
        end else begin
          regRdData[31:ALIGN_BITS] = rxBase[regSlot];
          regRdData[1] = rxDone[regSlot];
          regRdData[0] = rxEn[regSlot];
          if (regSlot == '0) regRdData[IDX_W+1:2] = rxIdx;
        end
      end
      KIND_LEN:  if (!regRing) regRdData[TX_LEN_W-1:0] = txLenR[regSlot];
      KIND_STAT: begin
        if (!regRing) regRdData[5:0] = txStat[regSlot];
        else          regRdData[RX_STAT_W-1:0] = rxStat[regSlot];
      end
      default: regRdData = '0;
    endcase
  end

  // R4: a recorded send leaves the serviced slot marked done
  a_r4_done_set: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.txRecord && !regWrEn) |=> txDone[$past(txIdx)]);

  // R8: a stored frame leaves the serviced slot marked done
  a_r8_done_set: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rxRecord && !regWrEn) |=> rxDone[$past(rxIdx)]);

endmodule

// File: rtl/mac_desc_ring.sv
module mac_desc_ring
  import mac_ring_pkg::*;
#(
  parameter int RING_DEPTH = 4,
  parameter int ALIGN_BITS = 11,
  parameter int TX_LEN_W   = 11,
  parameter int TX_LEN_MAX = 1518,
  parameter int RX_LEN_W   = 14,
  parameter int RX_FLAG_W  = 9,
  localparam int IDX_W     = $clog2(RING_DEPTH),
  localparam int REG_AW    = 1 + IDX_W + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  output logic                 txReq,
  output logic [31:0]          txBufAddr,
  output logic [TX_LEN_W-1:0]  txLen,
  input  logic                 txComplete,
  input  logic                 txAbort,
  input  logic                 txExcessCol,
  input  logic [3:0]           txColCount,
  output logic                 rxBufReady,
  output logic [31:0]          rxBufAddr,
  input  logic                 rxFrameEnd,
  input  logic [RX_LEN_W-1:0]  rxLen,
  input  logic [RX_FLAG_W-1:0] rxFlags
);

  logic [IDX_W-1:0] txIdx;
  logic [IDX_W-1:0] rxIdx;
  logic             missPending;
  logic             txCurReady;
  logic             rxCurReady;
  ringStrobe_t      strobe;

  ring_ctrl #(.RING_DEPTH(RING_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .txCurReady(txCurReady), .rxCurReady(rxCurReady),
    .txComplete(txComplete), .rxFrameEnd(rxFrameEnd),
    .txIdx(txIdx), .rxIdx(rxIdx), .missPending(missPending),
    .txReq(txReq), .strobe(strobe)
  );

  ring_datapath #(
    .RING_DEPTH(RING_DEPTH), .ALIGN_BITS(ALIGN_BITS), .TX_LEN_W(TX_LEN_W),
    .TX_LEN_MAX(TX_LEN_MAX), .RX_LEN_W(RX_LEN_W), .RX_FLAG_W(RX_FLAG_W)
  ) u_data (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .txIdx(txIdx), .rxIdx(rxIdx), .missPending(missPending), .strobe(strobe),
    .txAbort(txAbort), .txExcessCol(txExcessCol), .txColCount(txColCount),
    .rxLen(rxLen), .rxFlags(rxFlags),
    .txCurReady(txCurReady), .rxCurReady(rxCurReady),
    .txBufAddr(txBufAddr), .txLen(txLen), .rxBufAddr(rxBufAddr)
  );

  assign rxBufReady = rxCurReady;

  // R3: the offered byte count never exceeds the cap
  a_r3_len_cap: assert property (@(posedge clk) disable iff (!rstN)
    txReq |-> (txLen <= TX_LEN_W'(TX_LEN_MAX)));

  // R4: an accepted completion moves the send index
  a_r4_tx_advance: assert property (@(posedge clk) disable iff (!rstN)
    (txComplete && txReq) |=> (txIdx != $past(txIdx)));

  // R9: a dropped frame leaves the receive index where it was
  a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rxFrameEnd && !rxBufReady) |=> $stable(rxIdx));

endmodule

// File: tb/mac_desc_ring_tb.sv
module mac_desc_ring_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        txReq;
  logic [31:0] txBufAddr;
  logic [10:0] txLen;
  logic        txComplete = 1'b0;
  logic        txAbort = 1'b0;
  logic        txExcessCol = 1'b0;
  logic [3:0]  txColCount = '0;
  logic        rxBufReady;
  logic [31:0] rxBufAddr;
  logic        rxFrameEnd = 1'b0;
  logic [13:0] rxLen = '0;
  logic [8:0]  rxFlags = '0;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_desc_ring u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .txReq(txReq), .txBufAddr(txBufAddr), .txLen(txLen),
    .txComplete(txComplete), .txAbort(txAbort), .txExcessCol(txExcessCol),
    .txColCount(txColCount), .rxBufReady(rxBufReady), .rxBufAddr(rxBufAddr),
    .rxFrameEnd(rxFrameEnd), .rxLen(rxLen), .rxFlags(rxFlags)
  );

  // {len[10:0], abort, excess, count[3:0], expLen[10:0], expStat[5:0]}
  localparam logic [33:0] TX_VEC [4] = '{
    {11'd60,   1'b0, 1'b0, 4'd0,  11'd60,   6'd0},
    {11'd1518, 1'b0, 1'b0, 4'd3,  11'd1518, 6'd12},
    {11'd2000, 1'b1, 1'b1, 4'd15, 11'd1518, 6'd63},
    {11'd1519, 1'b1, 1'b0, 4'd5,  11'd1518, 6'd21}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic swWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic swRead(input logic [4:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic txFinish(input logic ab, input logic ex, input logic [3:0] cnt);
    @(negedge clk);
    txComplete = 1'b1; txAbort = ab; txExcessCol = ex; txColCount = cnt;
    @(negedge clk);
    txComplete = 1'b0; txAbort = 1'b0; txExcessCol = 1'b0; txColCount = '0;
  endtask

  task automatic rxFrame(input logic [13:0] len, input logic [8:0] fl);
    @(negedge clk);
    rxFrameEnd = 1'b1; rxLen = len; rxFlags = fl;
    @(negedge clk);
    rxFrameEnd = 1'b0; rxLen = '0; rxFlags = '0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not complete");
    finish();
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      swRead({1'b0, 2'(s), 2'd0}, rd); check(rd, 32'h0, "R1 tx addr reset");
      swRead({1'b1, 2'(s), 2'd0}, rd); check(rd, 32'h0, "R1 rx addr reset");
    end
    swRead({1'b0, 2'd0, 2'd2}, rd); check(rd, 32'h0, "R1 tx status reset");
    check({31'd0, txReq}, 32'd1 - 32'd1, "R1 txReq low");

    // R5 stall: slot 1 enabled while slot 0 is idle
    swWrite({1'b0, 2'd1, 2'd1}, 32'd100);
    swWrite({1'b0, 2'd1, 2'd0}, 32'h0000_1801);
    #1;
    check({31'd0, txReq}, 32'd0, "R5 no skip to later slot");
    swRead({1'b0, 2'd0, 2'd0}, rd); check({30'd0, rd[3:2]}, 32'd0, "R5 index held");

    // table walk over all send slots: R2 R3 R4 R6 R7 R11
    for (int i = 0; i < 4; i++) begin
      base = 32'(i + 1) << 11;
      swWrite({1'b0, 2'(i), 2'd1}, {21'd0, TX_VEC[i][33:23]});
      swWrite({1'b0, 2'(i), 2'd0}, base | 32'h21);   // bit 5 must be ignored (R6)
      #1;
      check({31'd0, txReq}, 32'd1, "R2 txReq for ready slot");
      check(txBufAddr, base, "R2 buffer address");
      check({21'd0, txLen}, {21'd0, TX_VEC[i][16:6]}, "R3 length cap");
      txFinish(TX_VEC[i][22], TX_VEC[i][21], TX_VEC[i][20:17]);
      swRead({1'b0, 2'(i), 2'd2}, rd);
      check(rd, {26'd0, TX_VEC[i][5:0]}, "R4 send status fields");
      swRead({1'b0, 2'(i), 2'd0}, rd);
      check(rd & ~32'hC, base | 32'h3, "R4 R6 done set, low bits ignored");
      swRead({1'b0, 2'd0, 2'd0}, rd);
      check({30'd0, rd[3:2]}, 32'((i + 1) % 4), "R7 R11 current index");
    end
    #1;
    check({31'd0, txReq}, 32'd0, "R4 done slot not resent");
    swRead({1'b0, 2'd2, 2'd0}, rd); check({30'd0, rd[3:2]}, 32'd0, "R7 index only in slot 0");

    // R6 acknowledge by writing zero
    swWrite({1'b0, 2'd0, 2'd0}, 32'h0);
    swRead({1'b0, 2'd0, 2'd0}, rd); check(rd, 32'h0, "R6 zero write clears enable and done");
    check({31'd0, txReq}, 32'd0, "R6 cleared slot not offered");

    // receive: frame with no slot (R9)
    rxFrame(14'd64, 9'h000);
    swRead({1'b1, 2'd0, 2'd0}, rd); check(rd, 32'h0, "R9 dropped frame leaves slot 0");
    swRead({1'b1, 2'd0, 2'd2}, rd); check(rd, 32'h0, "R9 dropped frame writes no status");

    swWrite({1'b1, 2'd0, 2'd0}, 32'h0004_0001);
    swWrite({1'b1, 2'd1, 2'd0}, 32'h0004_0801);
    #1;
    check({31'd0, rxBufReady}, 32'd1, "R8 receive slot ready");
    check(rxBufAddr, 32'h0004_0000, "R8 receive buffer address");

    // CRC error frame: missed mark (R9), flag position (R8), summary (R10)
    rxFrame(14'd68, 9'h004);
    swRead({1'b1, 2'd0, 2'd2}, rd);
    check(rd, 32'd68 | (32'd1 << 14) | (32'd1 << 17) | (32'd1 << 24), "R8 R9 R10 crc frame status");
    swRead({1'b1, 2'd0, 2'd0}, rd);
    check(rd, 32'h0004_0000 | (32'd1 << 2) | 32'h3, "R8 done set, index 1");

    // dribble only: no summary, missed mark gone
    rxFrame(14'd1000, 9'h100);
    swRead({1'b1, 2'd1, 2'd2}, rd);
    check(rd, 32'd1000 | (32'd1 << 23), "R10 R9 dribble frame status");
    swRead({1'b1, 2'd0, 2'd0}, rd);
    check({30'd0, rd[3:2]}, 32'd2, "R8 receive index 2");
    swRead({1'b1, 2'd1, 2'd0}, rd);
    check({30'd0, rd[3:2]}, 32'd0, "R7 receive index only in slot 0");

    // slot 2 not enabled: frame dropped, index held (R9)
    rxFrame(14'd80, 9'h001);
    swRead({1'b1, 2'd0, 2'd0}, rd);
    check({30'd0, rd[3:2]}, 32'd2, "R9 index held on drop");
    swRead({1'b1, 2'd2, 2'd2}, rd);
    check(rd, 32'h0, "R9 no status in unready slot");

    finish();
  end

endmodule